// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs a single management transaction from a station controller to an Ethernet PHY over the two-wire MDC/MDIO management bus. A request pulse carries the direction, a 5-bit PHY address, a 5-bit register address and, for a write, 16 data bits. The block then produces the whole serial frame. That frame is a run of ones as preamble, the start and opcode fields, both addresses and then either the write payload or a receive window for the PHY's reply. At the end it raises a one-cycle completion strobe, and for a read it returns the captured 16-bit value.

MDC is made by dividing the system clock. Each MDC high phase and each MDC low phase lasts `HALF_DIV` system clocks. The block leaves the pad to the chip: it gives a data-out bit, an output-enable and a sampled data-in bit, and the tri-state buffer sits outside. The block knows nothing about what any PHY register means, and it handles one request at a time.

Top module: `mdio_master`

## Requirements
- R1: After a request is accepted, the first 32 serial bits are all 1 and are driven with `mdio_oe_o` high.
- R2: The preamble is followed by the start code 0 then 1, and then the direction code: 1,0 for a read (`rd_i`=1) or 0,1 for a write (`rd_i`=0).
- R3: The PHY address and then the register address follow, each 5 bits with the most significant bit first. Both are latched at acceptance, so later changes on the request inputs have no effect.
- R4: A write continues with the turnaround bits 1,0 and then the 16 data bits, most significant first, for 64 driven bits in all. `mdio_oe_o` and `mdio_o` drop to 0 at the MDC falling edge that ends the last data bit.
- R5: A read releases `mdio_oe_o` at the MDC falling edge after the last register-address bit. It samples `mdio_i` on the next 17 MDC rising edges and keeps the last 16 samples as read data, first sample in the most significant position. Two more MDC pulses follow, and their samples are ignored.
- R6: MDC is low when idle. An accepted request starts with a low phase of `HALF_DIV` clocks, with bit 0 already on `mdio_o`. Every bit is then one high phase and one low phase of `HALF_DIV` clocks each. `mdio_o` and `mdio_oe_o` change only at MDC falling edges.
- R7: `start_i` is taken only while `busy_o` is low, and a start pulse while busy has no effect on the running frame.
- R8: `busy_o` rises at the clock edge that accepts a request. It falls at the edge that ends the last MDC low phase, and in that same cycle `done_o` is high for exactly one cycle.
- R9: `rdata_o` takes a new value only in the `done_o` cycle: the captured value for a read, 0 for a write. It holds that value until the next completion.
- R10: During and after reset, `mdc_o`, `mdio_o`, `mdio_oe_o`, `busy_o`, `done_o` and `rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address of the request |
| reg_addr_i | input | 5 | Register address of the request |
| wdata_i | input | 16 | Write payload |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 16 | Read result (0 after a write) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data toward the PHY |
| mdio_oe_o | output | 1 | Drive enable for the MDIO pad |
| mdio_i | input | 1 | Serial data from the pad |

## Verification
The bound checks assume that `start_i` and the request fields are never X once reset is released. They also assume `HALF_DIV` is at least 1, so that the phase-length counter has a real window to measure. `mdio_i` is left free by the checks. The bench plays the PHY: it changes `mdio_i` only during MDC low phases, so that each value is stable at the rising edge where the block samples it. During the two trailing read pulses it drives values that would corrupt the result if they were captured. It raises a start pulse in the middle of a frame and changes the request fields after acceptance. Requests are issued back to back in the completion cycle, which is the earliest legal point.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_BITS  = 32;
    localparam int CODE_W    = 2;
    localparam int HDR_BITS  = PRE_BITS + 2 * CODE_W + 2 * ADDR_W;
    localparam int RX_BITS   = DATA_W + 1;
    localparam int TAIL_BITS = 2;
    localparam int WR_BITS   = HDR_BITS + CODE_W + DATA_W;
    localparam int RD_BITS   = HDR_BITS + RX_BITS + TAIL_BITS;
    localparam int FRAME_W   = WR_BITS;
    localparam int IDX_W     = $clog2(RD_BITS + 1);

    localparam logic [CODE_W-1:0] SOF_CODE = 2'b01;
    localparam logic [CODE_W-1:0] OP_READ  = 2'b10;
    localparam logic [CODE_W-1:0] OP_WRITE = 2'b01;
    localparam logic [CODE_W-1:0] TA_CODE  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              st;
        logic [FRAME_W-1:0]  tx;
        logic [IDX_W-1:0]    idx;
        logic [IDX_W-1:0]    drv;
        logic [IDX_W-1:0]    last;
        logic                rd;
        logic                mdc;
        logic                dout;
        logic                oe;
        logic                done;
        logic [DATA_W-1:0]   rdata;
    } mst_regs_t;

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic tick_o
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (hold_i || cnt_q == CNT_LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = (cnt_q == CNT_LAST) && !hold_i;

endmodule

// File: rtl/mdio_frame_builder.sv
module mdio_frame_builder
    import mdio_pkg::*;
(
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   phy_addr_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [FRAME_W-1:0]  frame_o,
    output logic [IDX_W-1:0]    drv_len_o,
    output logic [IDX_W-1:0]    bit_cnt_o
);
    localparam int RD_PAD = FRAME_W - HDR_BITS;

    logic [HDR_BITS-1:0] hdr;

    always_comb begin
        hdr = {{PRE_BITS{1'b1}}, SOF_CODE, (rd_i ? OP_READ : OP_WRITE),
               phy_addr_i, reg_addr_i};
        if (rd_i) begin
            frame_o   = {hdr, {RD_PAD{1'b0}}};
            drv_len_o = IDX_W'(HDR_BITS);
            bit_cnt_o = IDX_W'(RD_BITS);
        end else begin
            frame_o   = {hdr, TA_CODE, wdata_i};
            drv_len_o = IDX_W'(WR_BITS);
            bit_cnt_o = IDX_W'(WR_BITS);
        end
    end

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear_i) begin
            sh_d = '0;
        end else if (shift_i) begin
            sh_d = {sh_q[WIDTH-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign data_o = sh_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [4:0]        phy_addr_i,
    input  logic [4:0]        reg_addr_i,
    input  logic [15:0]       wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       rdata_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    localparam logic [IDX_W-1:0] WIN_LO = IDX_W'(HDR_BITS);
    localparam logic [IDX_W-1:0] WIN_HI = IDX_W'(HDR_BITS + RX_BITS);

    mst_regs_t r_d, r_q;

    logic               tick;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   drv_len;
    logic [IDX_W-1:0]   bit_cnt;
    logic [DATA_W-1:0]  rx_data;
    logic               rx_clear;
    logic               rx_shift;
    logic               in_win;
    logic [IDX_W-1:0]   idx_nx;

    mdio_phase_timer #(.HALF_DIV(HALF_DIV)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (r_q.st == ST_IDLE),
        .tick_o (tick)
    );

    mdio_frame_builder build_i (
        .rd_i       (rd_i),
        .phy_addr_i (phy_addr_i),
        .reg_addr_i (reg_addr_i),
        .wdata_i    (wdata_i),
        .frame_o    (frame),
        .drv_len_o  (drv_len),
        .bit_cnt_o  (bit_cnt)
    );

    mdio_rx_shift #(.WIDTH(DATA_W)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (rx_clear),
        .shift_i (rx_shift),
        .bit_i   (mdio_i),
        .data_o  (rx_data)
    );

    assign in_win = r_q.rd && (r_q.idx >= WIN_LO) && (r_q.idx < WIN_HI);
    assign idx_nx = r_q.idx + 1'b1;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        rx_clear = 1'b0;
        rx_shift = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_LOW;
                    r_d.tx   = frame << 1;
                    r_d.dout = frame[FRAME_W-1];
                    r_d.oe   = 1'b1;
                    r_d.mdc  = 1'b0;
                    r_d.idx  = '0;
                    r_d.drv  = drv_len;
                    r_d.last = bit_cnt;
                    r_d.rd   = rd_i;
                    rx_clear = 1'b1;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    if (r_q.idx == r_q.last) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.rdata = r_q.rd ? rx_data : '0;
                    end else begin
                        r_d.st   = ST_HIGH;
                        r_d.mdc  = 1'b1;
                        rx_shift = in_win;
                    end
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    r_d.st  = ST_LOW;
                    r_d.mdc = 1'b0;
                    r_d.idx = idx_nx;
                    if (idx_nx < r_q.drv) begin
                        r_d.dout = r_q.tx[FRAME_W-1];
                        r_d.tx   = r_q.tx << 1;
                        r_d.oe   = 1'b1;
                    end else begin
                        r_d.dout = 1'b0;
                        r_d.oe   = 1'b0;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = r_q.done;
    assign rdata_o   = r_q.rdata;
    assign mdc_o     = r_q.mdc;
    assign mdio_o    = r_q.dout;
    assign mdio_oe_o = r_q.oe;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int HALF_DIV = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] rdata_o,
    input logic        mdc_o,
    input logic        mdio_o,
    input logic        mdio_oe_o
);
    logic        mdc_prev_q;
    logic        busy_prev_q;
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_prev_q  <= 1'b0;
            busy_prev_q <= 1'b0;
            run_q       <= '0;
        end else begin
            mdc_prev_q  <= mdc_o;
            busy_prev_q <= busy_o;
            if ((mdc_o != mdc_prev_q) || (busy_o && !busy_prev_q)) begin
                run_q <= 16'd1;
            end else if (run_q != 16'hFFFF) begin
                run_q <= run_q + 16'd1;
            end
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R6
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mdc_o);

    // R5
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mdio_oe_o);

    // R6
    high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    // R6
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (mdc_o != mdc_prev_q)) |-> (run_q == 16'(HALF_DIV)));

    // R9
    rdata_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_o) |-> done_o);

endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
    localparam int HALF = 20;
    localparam int HDR  = 46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        mdio_i = 1'b0;
    logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rdata_o;

    always #2 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    typedef struct packed {
        logic        mdc;
        logic        oe;
        logic        dout;
        logic        busy;
        logic        done;
        logic        din;
        logic [15:0] rdata;
        logic [3:0]  rq;
    } exp_t;

    exp_t        q[$];
    logic [15:0] held = '0;
    int          n_cmp = 0;
    int          n_bad = 0;

    function automatic exp_t mk(logic c, logic o, logic d, logic b, logic dn,
                                logic di, logic [15:0] rv, int rq);
        exp_t e;
        e.mdc = c; e.oe = o; e.dout = d; e.busy = b; e.done = dn;
        e.din = di; e.rdata = rv; e.rq = 4'(rq);
        return e;
    endfunction

    // one clock: compare outputs against the model, then drive the PHY line
    task automatic step();
        exp_t e;
        int   tag;
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else e = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, held, 10); // R10 / idle
        n_cmp++;
        if (mdc_o !== e.mdc || mdio_oe_o !== e.oe || mdio_o !== e.dout ||
            busy_o !== e.busy || done_o !== e.done || rdata_o !== e.rdata) begin
            n_bad++;
            tag = e.rq;
            if (mdc_o !== e.mdc) tag = 6;                         // R6
            else if (busy_o !== e.busy || done_o !== e.done) tag = 8; // R8
            else if (rdata_o !== e.rdata) tag = 9;                // R9
            $display("FAIL R%0d t=%0t got mdc=%b oe=%b dout=%b busy=%b done=%b rdata=%h exp mdc=%b oe=%b dout=%b busy=%b done=%b rdata=%h",
                     tag, $time, mdc_o, mdio_oe_o, mdio_o, busy_o, done_o, rdata_o,
                     e.mdc, e.oe, e.dout, e.busy, e.done, e.rdata);
        end
        mdio_i = e.din;
    endtask

    // behavioural model of one frame, one entry per system clock
    task automatic build(logic rd, logic [4:0] pa, logic [4:0] ra,
                         logic [15:0] wd, logic ta, logic [15:0] rxd);
        logic        b[0:64];
        logic        dn[0:64];
        int          rq[0:64];
        int          n = 0;
        int          drv;
        int          tot;
        int          rtail;
        logic [16:0] rxs;
        logic [15:0] nv;
        rxs = {ta, rxd};
        rtail = rd ? 5 : 4;
        for (int i = 0; i < 65; i++) begin b[i] = 1'b0; dn[i] = 1'b1; rq[i] = rtail; end
        for (int i = 0; i < 32; i++) begin b[n] = 1'b1; rq[n] = 1; n++; end      // R1
        b[n] = 1'b0; rq[n] = 2; n++; b[n] = 1'b1; rq[n] = 2; n++;              // R2
        b[n] = rd;   rq[n] = 2; n++; b[n] = !rd;  rq[n] = 2; n++;
        for (int i = 4; i >= 0; i--) begin b[n] = pa[i]; rq[n] = 3; n++; end    // R3
        for (int i = 4; i >= 0; i--) begin b[n] = ra[i]; rq[n] = 3; n++; end
        if (!rd) begin                                                         // R4
            b[n] = 1'b1; rq[n] = 4; n++; b[n] = 1'b0; rq[n] = 4; n++;
            for (int i = 15; i >= 0; i--) begin b[n] = wd[i]; rq[n] = 4; n++; end
            drv = n; tot = n;
        end else begin                                                         // R5
            drv = n; tot = n + 19;
            for (int i = 0; i < 17; i++) dn[HDR + i] = rxs[16 - i];
            dn[HDR + 17] = ~rxd[0];
            dn[HDR + 18] = rxd[0];
        end
        for (int k = 0; k < HALF; k++)                                         // R6
            q.push_back(mk(1'b0, 1'b1, b[0], 1'b1, 1'b0, dn[0], held, 6));
        for (int i = 0; i < tot; i++) begin
            for (int k = 0; k < HALF; k++)
                q.push_back(mk(1'b1, i < drv, (i < drv) ? b[i] : 1'b0, 1'b1, 1'b0,
                               dn[i], held, rq[i]));
            for (int k = 0; k < HALF; k++)
                q.push_back(mk(1'b0, (i + 1) < drv, ((i + 1) < drv) ? b[i + 1] : 1'b0,
                               1'b1, 1'b0, ((i + 1) < tot) ? dn[i + 1] : 1'b1, held,
                               ((i + 1) < tot) ? rq[i + 1] : rtail));
        end
        nv = rd ? rxd : 16'h0000;                                              // R9
        q.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, nv, 8));            // R8
        held = nv;
    endtask

    // issue a request; glitch_at > 0 raises start again mid-frame (R7)
    task automatic run_txn(logic rd, logic [4:0] pa, logic [4:0] ra,
                           logic [15:0] wd, logic ta, logic [15:0] rxd, int glitch_at);
        int k = 0;
        build(rd, pa, ra, wd, ta, rxd);
        start_i = 1'b1; rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
        step();
        start_i = 1'b0;
        // R3: fields change after acceptance and must not matter
        rd_i = !rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;
        while (q.size() > 0) begin
            k++;
            start_i = (glitch_at > 0 && k == glitch_at);
            step();
        end
        start_i = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hung exp done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (4) step();
        rst_n = 1'b1;
        repeat (3) step();
        // R1 R2 R3 R4: write frame
        run_txn(1'b0, 5'h01, 5'h00, 16'hA5C3, 1'b0, 16'h0000, 0);
        repeat (2) step();
        // R5: read frame, turnaround sample discarded
        run_txn(1'b1, 5'h1F, 5'h12, 16'h0000, 1'b1, 16'h1234, 0);
        // R8: back to back in the completion cycle, R9 write clears rdata
        run_txn(1'b0, 5'h00, 5'h1F, 16'hFFFF, 1'b0, 16'h0000, 0);
        run_txn(1'b1, 5'h15, 5'h0A, 16'h0000, 1'b0, 16'h8001, 0);
        repeat (3) step();
        // R7: start pulses while busy are ignored
        run_txn(1'b0, 5'h0A, 5'h15, 16'h0F0F, 1'b0, 16'h0000, 300);
        run_txn(1'b1, 5'h03, 5'h11, 16'h0000, 1'b1, 16'hFFFE, 2000);
        repeat (5) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule